// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Power-Up Initializer

This block owns the refresh duty of a 1024-row asynchronous DRAM. Out of reset it waits a programmable start-up delay. It then runs a fixed number of back-to-back refresh cycles without asking for the bus. Only after that does it raise `init_done_o`, which tells the access controller that normal reads and writes may begin.

From then on an interval timer adds one refresh credit per period. Credits are capped, so a small backlog can build while the access controller keeps the memory busy. The block asks for the bus with a request/grant handshake. It starts a refresh only when the grant is held and no row is open. Each refresh is a RAS strobe of one of two kinds:
- Chip-select-before-RAS, where the DRAM supplies the row from its own counter.
- RAS-only, where the block drives the row from a 10-bit counter of its own. That counter wraps after row 1023.

All analog timing is expressed as whole clock cycles set by parameters. The low-power variant, with its eight-times longer retention, is chosen by a parameter that stretches the refresh period by a factor of eight.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, ras_n_o, cs_n_o and we_n_o are 1, addr_o is 0, and init_done_o and ref_req_o are 0.
- R2: No RAS falling edge occurs during the first STARTUP_CYC clock cycles after reset is released.
- R3: Exactly INIT_REFRESHES refresh strobes (8 by default) complete before init_done_o rises. They need no grant, init_done_o stays low throughout them, and once high it stays high until reset.
- R4: In a chip-select-first refresh (ras_only_i = 0), cs_n_o is low for T_SETUP cycles before ras_n_o falls and stays low for T_CHR cycles after the fall. we_n_o is 1 at the fall, and cs_n_o is high again when ras_n_o rises.
- R5: In a RAS-only refresh (ras_only_i = 1), cs_n_o stays 1 and addr_o carries the block's row counter while ras_n_o is low.
- R6: The row counter starts at 0 and advances by one after each RAS-only refresh, wrapping from 1023 to 0. Chip-select-first refreshes leave it unchanged.
- R7: After initialization, ref_req_o is 1 while a credit is pending or a refresh is in progress, and 0 otherwise. No refresh starts while ref_gnt_i is 0.
- R8: No refresh starts while row_open_i is 1, even with ref_gnt_i high. The credit is kept until the row closes.
- R9: Pending credits saturate at MAX_PEND (4 by default). After more than four periods without a grant, exactly four refreshes run back to back once the grant returns.
- R10: With the grant held, successive refresh strobes are REF_INTERVAL_CYC cycles apart, or 8*REF_INTERVAL_CYC cycles apart when LOW_POWER = 1.
- R11: ref_busy_o is 1 for the whole refresh (T_SETUP + T_RAS + T_RP cycles), and ras_n_o and cs_n_o are both high whenever ref_busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_only_i | input | 1 | Refresh style for the next refresh: 1 = RAS-only, 0 = chip-select first |
| ref_gnt_i | input | 1 | Bus grant from the access controller |
| row_open_i | input | 1 | Access controller has a row open |
| ref_req_o | output | 1 | Refresh needs the bus |
| ref_busy_o | output | 1 | Refresh cycle in progress; the block drives the DRAM pins |
| init_done_o | output | 1 | Start-up delay and initialization refreshes are finished |
| ras_n_o | output | 1 | Row strobe to the DRAM, active low |
| cs_n_o | output | 1 | Chip select to the DRAM, active low |
| we_n_o | output | 1 | Write enable to the DRAM, held high by refresh |
| addr_o | output | ROW_W | Row address for RAS-only refresh |

## Verification
The bench counts initialization strobes against the release of `init_done_o`. A scheduler that opened the bus early, or ran seven or nine init cycles, shows up as a wrong strobe count at that edge.

It withholds the grant for five periods so that the credit counter has to saturate. An unbounded or off-by-one counter then produces a fifth strobe inside the burst window.

It runs more than 1024 RAS-only refreshes and checks every strobed row. This catches a counter that fails to wrap, or one that also steps during chip-select-first cycles.

It checks the chip-select lead and hold around each strobe. A sequencer that dropped the lead would turn a refresh into a plain strobe, and one that held write enable low would turn it into a test-mode entry.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SETUP,
    SEQ_STROBE,
    SEQ_PRECH
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_WAIT,
    PH_INIT,
    PH_RUN
  } phase_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/ref_timebase.sv
module ref_timebase
  import dram_ref_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 20000,
  parameter int unsigned TICK_CYC    = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic startup_done_o,
  output logic tick_o
);
  localparam int unsigned SW = cnt_w(STARTUP_CYC);
  localparam int unsigned TW = cnt_w(TICK_CYC);
  localparam logic [SW-1:0] ST_END = SW'(STARTUP_CYC - 1);
  localparam logic [TW-1:0] TK_END = TW'(TICK_CYC - 1);

  logic [SW-1:0] st_cnt_q;
  logic          st_done_q;
  logic [TW-1:0] iv_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_cnt_q  <= '0;
      st_done_q <= 1'b0;
    end else if (!st_done_q) begin
      if (st_cnt_q == ST_END) st_done_q <= 1'b1;
      else                    st_cnt_q  <= st_cnt_q + 1'b1;
    end
  end

  // interval counter restarts whenever run drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          iv_cnt_q <= '0;
    else if (!run_i || iv_cnt_q == TK_END) iv_cnt_q <= '0;
    else                                  iv_cnt_q <= iv_cnt_q + 1'b1;
  end

  assign startup_done_o = st_done_q;
  assign tick_o         = run_i && (iv_cnt_q == TK_END);

endmodule

// File: rtl/ref_credit.sv
module ref_credit
  import dram_ref_pkg::*;
#(
  parameter int unsigned MAX_PEND = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic pending_o
);
  localparam int unsigned PW = cnt_w(MAX_PEND);
  localparam logic [PW-1:0] PMAX = PW'(MAX_PEND);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (inc_i && !dec_i) begin
      if (cnt_q != PMAX) cnt_q <= cnt_q + 1'b1;
    end else if (dec_i && !inc_i) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pending_o = (cnt_q != '0);

endmodule

// File: rtl/ref_cycle_seq.sv
module ref_cycle_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned ROW_W   = 10,
  parameter int unsigned T_SETUP = 1,
  parameter int unsigned T_RAS   = 6,
  parameter int unsigned T_CHR   = 2,
  parameter int unsigned T_RP    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ras_only_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ras_n_o,
  output logic             cs_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int unsigned MAX_A = (T_SETUP > T_RAS) ? T_SETUP : T_RAS;
  localparam int unsigned MAX_T = (MAX_A > T_RP) ? MAX_A : T_RP;
  localparam int unsigned CW    = cnt_w(MAX_T);
  localparam logic [CW-1:0] SU_END = CW'(T_SETUP - 1);
  localparam logic [CW-1:0] RS_END = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RP_END = CW'(T_RP - 1);
  localparam logic [CW-1:0] CHR_LIM = CW'(T_CHR);

  seq_state_e       state_q;
  logic [CW-1:0]    cnt_q;
  logic             row_mode_q;
  logic [ROW_W-1:0] row_q;
  logic             last;
  logic             cs_act;

  always_comb begin
    case (state_q)
      SEQ_SETUP:  last = (cnt_q == SU_END);
      SEQ_STROBE: last = (cnt_q == RS_END);
      SEQ_PRECH:  last = (cnt_q == RP_END);
      default:    last = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      cnt_q      <= '0;
      row_mode_q <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q    <= SEQ_SETUP;
          cnt_q      <= '0;
          row_mode_q <= ras_only_i;
        end
        SEQ_SETUP:  if (last) begin state_q <= SEQ_STROBE; cnt_q <= '0; end
                    else cnt_q <= cnt_q + 1'b1;
        SEQ_STROBE: if (last) begin state_q <= SEQ_PRECH;  cnt_q <= '0; end
                    else cnt_q <= cnt_q + 1'b1;
        SEQ_PRECH:  if (last) begin state_q <= SEQ_IDLE;   cnt_q <= '0; end
                    else cnt_q <= cnt_q + 1'b1;
        default:    state_q <= SEQ_IDLE;
      endcase
    end
  end

  // own row counter, only stepped by RAS-only cycles; wraps naturally
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                row_q <= '0;
    else if (done_o && row_mode_q) row_q <= row_q + 1'b1;
  end

  assign cs_act  = !row_mode_q &&
                   ((state_q == SEQ_SETUP) || (state_q == SEQ_STROBE && cnt_q < CHR_LIM));
  assign busy_o  = (state_q != SEQ_IDLE);
  assign done_o  = (state_q == SEQ_PRECH) && last;
  assign ras_n_o = (state_q != SEQ_STROBE);
  assign cs_n_o  = !cs_act;
  assign we_n_o  = 1'b1;
  assign addr_o  = (row_mode_q && busy_o) ? row_q : '0;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int unsigned STARTUP_CYC      = 20000,
  parameter int unsigned REF_INTERVAL_CYC = 1560,
  parameter bit          LOW_POWER        = 1'b0,
  parameter int unsigned INIT_REFRESHES   = 8,
  parameter int unsigned MAX_PEND         = 4,
  parameter int unsigned ROW_W            = 10,
  parameter int unsigned T_SETUP          = 1,
  parameter int unsigned T_RAS            = 6,
  parameter int unsigned T_CHR            = 2,
  parameter int unsigned T_RP             = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_only_i,
  input  logic             ref_gnt_i,
  input  logic             row_open_i,
  output logic             ref_req_o,
  output logic             ref_busy_o,
  output logic             init_done_o,
  output logic             ras_n_o,
  output logic             cs_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] addr_o
);
  localparam int unsigned TICK_CYC = LOW_POWER ? REF_INTERVAL_CYC * 8 : REF_INTERVAL_CYC;
  localparam int unsigned IW       = cnt_w(INIT_REFRESHES);
  localparam logic [IW-1:0] INIT_N = IW'(INIT_REFRESHES);

  phase_e        phase_q;
  logic [IW-1:0] init_left_q;
  logic          startup_done, tick, pending;
  logic          seq_busy, seq_done, start;
  logic          run;

  assign run = (phase_q == PH_RUN);

  ref_timebase #(
    .STARTUP_CYC(STARTUP_CYC),
    .TICK_CYC   (TICK_CYC)
  ) u_timebase (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (run),
    .startup_done_o(startup_done),
    .tick_o        (tick)
  );

  ref_credit #(
    .MAX_PEND(MAX_PEND)
  ) u_credit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (tick),
    .dec_i    (seq_done && run),
    .pending_o(pending)
  );

  ref_cycle_seq #(
    .ROW_W  (ROW_W),
    .T_SETUP(T_SETUP),
    .T_RAS  (T_RAS),
    .T_CHR  (T_CHR),
    .T_RP   (T_RP)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .ras_only_i(ras_only_i),
    .busy_o    (seq_busy),
    .done_o    (seq_done),
    .ras_n_o   (ras_n_o),
    .cs_n_o    (cs_n_o),
    .we_n_o    (we_n_o),
    .addr_o    (addr_o)
  );

  // init refreshes run without arbitration: no access may precede them
  always_comb begin
    start = 1'b0;
    if (!seq_busy) begin
      case (phase_q)
        PH_INIT: start = (init_left_q != '0);
        PH_RUN:  start = pending && ref_gnt_i && !row_open_i;
        default: start = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_WAIT;
      init_left_q <= INIT_N;
    end else begin
      case (phase_q)
        PH_WAIT: if (startup_done) phase_q <= PH_INIT;
        PH_INIT: if (seq_done) begin
          init_left_q <= init_left_q - 1'b1;
          if (init_left_q == IW'(1)) phase_q <= PH_RUN;
        end
        PH_RUN:  phase_q <= PH_RUN;
        default: phase_q <= PH_WAIT;
      endcase
    end
  end

  assign init_done_o = run;
  assign ref_busy_o  = seq_busy;
  assign ref_req_o   = run && (pending || seq_busy);

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_gnt_i,
  input logic row_open_i,
  input logic ref_req_o,
  input logic ref_busy_o,
  input logic init_done_o,
  input logic ras_n_o,
  input logic cs_n_o
);

  p_cs_lead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !cs_n_o) |-> $past(!cs_n_o && ras_n_o));

  p_cs_high_at_ras_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> cs_n_o);

  p_init_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  p_start_needs_bus_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ref_busy_o) && init_done_o) |-> $past(ref_gnt_i && !row_open_i));

  p_req_during_refresh_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_o && ref_busy_o) |-> ref_req_o);

  p_strobe_in_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> ref_busy_o);

  p_idle_pins_high_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_busy_o |-> (ras_n_o && cs_n_o));

endmodule

bind dram_refresh_sched dram_refresh_sched_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ref_gnt_i  (ref_gnt_i),
  .row_open_i (row_open_i),
  .ref_req_o  (ref_req_o),
  .ref_busy_o (ref_busy_o),
  .init_done_o(init_done_o),
  .ras_n_o    (ras_n_o),
  .cs_n_o     (cs_n_o)
);

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int STARTUP    = 50;
  localparam int INTERVAL   = 64;
  localparam int ROWS       = 1024;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ras_only_i = 1'b0;
  logic ref_gnt_i = 1'b0;
  logic row_open_i = 1'b0;
  logic ref_req_o, ref_busy_o, init_done_o, ras_n_o, cs_n_o, we_n_o;
  logic [9:0] addr_o;
  logic lp_req, lp_busy, lp_done, lp_ras_n, lp_cs_n, lp_we_n;
  logic [9:0] lp_addr;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dram_refresh_sched #(
    .STARTUP_CYC(STARTUP), .REF_INTERVAL_CYC(INTERVAL), .LOW_POWER(1'b0),
    .T_SETUP(1), .T_RAS(4), .T_CHR(2), .T_RP(3)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ras_only_i(ras_only_i), .ref_gnt_i(ref_gnt_i),
    .row_open_i(row_open_i), .ref_req_o(ref_req_o), .ref_busy_o(ref_busy_o),
    .init_done_o(init_done_o), .ras_n_o(ras_n_o), .cs_n_o(cs_n_o), .we_n_o(we_n_o),
    .addr_o(addr_o)
  );

  dram_refresh_sched #(
    .STARTUP_CYC(STARTUP), .REF_INTERVAL_CYC(INTERVAL), .LOW_POWER(1'b1),
    .T_SETUP(1), .T_RAS(4), .T_CHR(2), .T_RP(3)
  ) dut_lp (
    .clk_i(clk_i), .rst_ni(rst_ni), .ras_only_i(1'b0), .ref_gnt_i(1'b1),
    .row_open_i(1'b0), .ref_req_o(lp_req), .ref_busy_o(lp_busy),
    .init_done_o(lp_done), .ras_n_o(lp_ras_n), .cs_n_o(lp_cs_n), .we_n_o(lp_we_n),
    .addr_o(lp_addr)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) if (rst_ni) cyc++;

  // strobe monitor
  int fall_cnt = 0, last_fall = 0, first_fall = -1, gap = 0;
  int exp_row = 0, ro_falls = 0, wraps = 0, row_err = 0;
  bit prev_ras = 1, prev_cs = 1, hold_chk = 0;
  always @(negedge clk_i) if (rst_ni) begin
    if (hold_chk) begin
      check(cs_n_o == 1'b0, "R4 cs held low after ras fall", cs_n_o, 0);
      hold_chk = 0;
    end
    if (prev_ras && !ras_n_o) begin
      fall_cnt++;
      gap = cyc - last_fall;
      last_fall = cyc;
      if (fall_cnt == 1) first_fall = cyc;
      check(we_n_o == 1'b1, "R4 we high at strobe", we_n_o, 1);
      if (!ras_only_i) begin
        check(cs_n_o == 1'b0 && prev_cs == 1'b0, "R4 cs lead before ras", cs_n_o, 0);
        hold_chk = 1;
      end else begin
        check(cs_n_o == 1'b1, "R5 cs high in ras-only", cs_n_o, 1);
        check(int'(addr_o) == exp_row, "R5 strobed row", addr_o, exp_row);
        if (int'(addr_o) != exp_row) row_err++;
        if (exp_row == ROWS - 1) wraps++;
        exp_row = (exp_row + 1) % ROWS;
        ro_falls++;
      end
      if (fall_cnt <= 8) check(init_done_o == 1'b0, "R3 init_done low during init", init_done_o, 0);
    end
    prev_ras = ras_n_o;
    prev_cs  = cs_n_o;
  end

  int lp_falls = 0, lp_last = 0, lp_gap = 0;
  bit lp_prev = 1;
  always @(negedge clk_i) if (rst_ni) begin
    if (lp_prev && !lp_ras_n) begin
      lp_falls++;
      lp_gap = cyc - lp_last;
      lp_last = cyc;
    end
    lp_prev = lp_ras_n;
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk_i); #1; end
  endtask

  task automatic wait_falls(input int n);
    int target = fall_cnt + n;
    while (fall_cnt < target) step();
  endtask

  task automatic wait_idle();
    while (ref_busy_o) step();
  endtask

  task automatic t_reset();
    step(3);
    check(ras_n_o && cs_n_o && we_n_o, "R1 pins high in reset", {ras_n_o, cs_n_o, we_n_o}, 7);
    check(addr_o == '0, "R1 addr zero in reset", addr_o, 0);
    check(!init_done_o && !ref_req_o, "R1 init_done/req low", {init_done_o, ref_req_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_init();
    while (!init_done_o) step();
    check(fall_cnt == 8, "R3 init strobe count", fall_cnt, 8);
    check(first_fall >= STARTUP, "R2 no strobe in startup", first_fall, STARTUP);
  endtask

  task automatic t_handshake();
    int f0 = fall_cnt;
    step(3 * INTERVAL);
    check(fall_cnt == f0, "R7 no refresh without grant", fall_cnt - f0, 0);
    check(ref_req_o == 1'b1, "R7 req while pending", ref_req_o, 1);
    ref_gnt_i = 1'b1; row_open_i = 1'b1;
    step(2 * INTERVAL);
    check(fall_cnt == f0, "R8 deferred while row open", fall_cnt - f0, 0);
    row_open_i = 1'b0;
    step(3);
    check(fall_cnt == f0 + 1, "R8 refresh after row closes", fall_cnt - f0, 1);
    step(60);
  endtask

  task automatic t_saturate();
    int f0;
    wait_falls(1);
    ref_gnt_i = 1'b0;
    step(5 * INTERVAL);
    ref_gnt_i = 1'b1;
    f0 = fall_cnt;
    step(45);
    check(fall_cnt - f0 == 4, "R9 burst capped at four", fall_cnt - f0, 4);
  endtask

  task automatic t_interval();
    wait_falls(2);
    wait_falls(1);
    check(gap == INTERVAL, "R10 normal interval", gap, INTERVAL);
    step(20);
    check(ref_req_o == 1'b0, "R7 req low when nothing pending", ref_req_o, 0);
    check(ref_busy_o == 1'b0, "R11 busy low between refreshes", ref_busy_o, 0);
  endtask

  task automatic t_row_wrap();
    wait_idle();
    ras_only_i = 1'b1;
    while (ro_falls < ROWS + 6) step();
    check(wraps >= 1, "R6 row counter wrapped", wraps, 1);
    check(row_err == 0, "R6 row sequence", row_err, 0);
  endtask

  task automatic t_mixed();
    int r0;
    wait_idle();
    ras_only_i = 1'b0;
    wait_falls(3);
    wait_idle();
    r0 = exp_row;
    ras_only_i = 1'b1;
    wait_falls(1);
    check(row_err == 0 && exp_row == (r0 + 1) % ROWS, "R6 row held across cs-first", exp_row, (r0 + 1) % ROWS);
  endtask

  task automatic t_low_power();
    check(lp_falls >= 10, "R10 low-power refreshes seen", lp_falls, 10);
    check(lp_gap == 8 * INTERVAL, "R10 low-power interval", lp_gap, 8 * INTERVAL);
  endtask

  initial begin
    t_reset();
    t_init();
    t_handshake();
    t_saturate();
    t_interval();
    t_row_wrap();
    t_mixed();
    t_low_power();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule